// File: doc/BRIEF.md
# Dual-Clock Read/Write Memory with Address and Return Queues

This block is a word-addressed memory with one write port and one read port, each in its own clock domain, for systems where the write clock runs at least as fast as the read clock. The storage array is a simple one-clock dual-port RAM clocked by the write clock. Writes go straight into it and take effect at the next write-clock edge.

A read takes a round trip between the two domains. The read domain places the requested address into an asynchronous address queue. The write domain drains that queue and reads the RAM. One write cycle later it places the word into an asynchronous return queue. The read domain also keeps a copy of each request in a delay line. That delay line is set to the worst-case latency of the round trip. The return queue is popped only when the delayed copy arrives, so every read answers after a fixed number of read cycles and requests may be issued on consecutive read cycles.

The clock ratio is a parameter. The latency is LAT = 4 + ceil(5 / CLK_RATIO) read cycles, which gives 9 at a ratio of 1 and 7 at a ratio of 2.

Top module: `dcm_dual_clock_mem`

## Requirements
- R1: A word presented with `wr_en` high is stored at the next rising `wclk` edge. A later read of that address returns it, including at the highest address.
- R2: For a request sampled on rising `rclk` edge k, `rd_valid` is high for exactly the read cycle that follows edge k+LAT, where LAT = 4 + ceil(5/CLK_RATIO).
- R3: Each accepted request produces exactly one one-cycle `rd_valid` pulse, and there is no pulse without a request. Requests on consecutive `rclk` cycles produce pulses on consecutive cycles, in request order.
- R4: When `rd_valid` is high, `rd_data` holds the word stored at the requested address. `rd_data` keeps its value in every cycle where `rd_valid` is low.
- R5: While `rd_en` is low, `rd_addr` has no effect: no pulse appears and `rd_data` does not change.
- R6: While `wr_en` is low, `wr_addr` and `wr_data` leave the memory unchanged, which a later read shows.
- R7: While `rrst` is high and right after it is released, `rd_valid` is 0 and `rd_data` is 0.
- R8: Under back-to-back requests, neither queue is written while full. The return queue is never empty in the cycle where the delayed request asks for its word.
- R9: After two writes to one address, a read returns the second word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock, also clocks the RAM |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Returned word, registered |
| rd_valid | output | 1 | One-cycle pulse marking a returned word |

## Verification
The bench pins the exact return cycle of every request. If the delay line were one stage short or long, every pulse would land a cycle off. If it were shorter than the real round trip, the return queue would be empty when popped and words would be lost or shifted to later requests.

Long bursts of consecutive requests check for queue overflow and ordering. A design with a wrong full flag or wrong gray pointers would drop, repeat or reorder words there. A read sweep with `rd_en` low, a write cycle with `wr_en` low, and a double write to one address would expose a decoder that ignores its strobes or a RAM that keeps the older word.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;
  // integer division rounded up, used for cycle-count parameters
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dcm_sync.sv
`timescale 1ns/1ps
// two-flop synchronizer for gray-coded pointers
module dcm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcm_afifo.sv
`timescale 1ns/1ps
// asynchronous FIFO with gray pointers; head word is read combinationally
module dcm_afifo #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] ONE   = 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wbin_nxt, rgray_w;
  logic [AW:0] rbin, rgray, rbin_nxt, wgray_r;
  logic        do_push, do_pop;

  // write side
  assign do_push  = push && !full;
  assign wbin_nxt = wbin + ONE;
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (do_push) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end
  always_ff @(posedge wclk) begin
    if (do_push) mem[wbin[AW-1:0]] <= wdata;
  end
  dcm_sync #(.W(AW + 1)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w));
  assign full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});

  // read side
  assign do_pop   = pop && !empty;
  assign rbin_nxt = rbin + ONE;
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_pop) begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end
  dcm_sync #(.W(AW + 1)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r));
  assign empty = (rgray == wgray_r);
  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/dcm_ram.sv
`timescale 1ns/1ps
// one-clock simple dual-port RAM, registered read-first output
module dcm_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcm_dual_clock_mem.sv
`timescale 1ns/1ps
module dcm_dual_clock_mem
  import dcm_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CLK_RATIO = 2,  // wclk frequency / rclk frequency, >= 1
  parameter int FIFO_AW   = 3   // log2 of queue depth, >= 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  // worst case: 1 rclk + 3 wclk + 2 wclk + 3 rclk, in rclk cycles
  localparam int LAT = 4 + ceil_div(5, CLK_RATIO);

  logic              aq_full, aq_empty, aq_pop;
  logic [ADDR_W-1:0] aq_head;
  logic [DATA_W-1:0] ram_q, rq_head;
  logic              ram_rd_d, rq_full, rq_empty, rq_pop;
  logic [LAT-1:0]    req_dly;
  logic              dly_out;

  // address queue: rclk -> wclk
  dcm_afifo #(.WIDTH(ADDR_W), .AW(FIFO_AW)) u_addr_q (
    .wclk(rclk), .wrst(rrst), .push(rd_en), .wdata(rd_addr), .full(aq_full),
    .rclk(wclk), .rrst(wrst), .pop(aq_pop), .rdata(aq_head), .empty(aq_empty)
  );
  assign aq_pop = !aq_empty;

  dcm_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(wclk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(aq_pop), .raddr(aq_head), .rdata(ram_q)
  );

  // RAM word is ready one wclk after the read strobe
  always_ff @(posedge wclk) begin
    if (wrst) ram_rd_d <= 1'b0;
    else      ram_rd_d <= aq_pop;
  end

  // return queue: wclk -> rclk
  dcm_afifo #(.WIDTH(DATA_W), .AW(FIFO_AW)) u_ret_q (
    .wclk(wclk), .wrst(wrst), .push(ram_rd_d), .wdata(ram_q), .full(rq_full),
    .rclk(rclk), .rrst(rrst), .pop(rq_pop), .rdata(rq_head), .empty(rq_empty)
  );

  // request delay line sized to the worst-case round trip
  always_ff @(posedge rclk) begin
    if (rrst) req_dly <= '0;
    else      req_dly <= {req_dly[LAT-2:0], rd_en};
  end
  assign dly_out = req_dly[LAT-1];
  assign rq_pop  = dly_out && !rq_empty;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rq_pop;
      if (rq_pop) rd_data <= rq_head;
    end
  end

  // ---------------- assertions ----------------
  logic [7:0] outst;
  always_ff @(posedge rclk) begin
    if (rrst) outst <= '0;
    else      outst <= outst + {7'd0, rd_en} - {7'd0, rd_valid};
  end

  p_no_overflow_r8: assert property (@(posedge rclk) disable iff (rrst)
    rd_en |-> !aq_full);
  p_ret_no_overflow_r8: assert property (@(posedge wclk) disable iff (wrst)
    ram_rd_d |-> !rq_full);
  p_word_ready_r8: assert property (@(posedge rclk) disable iff (rrst)
    dly_out |-> !rq_empty);
  p_valid_has_req_r3: assert property (@(posedge rclk) disable iff (rrst)
    rd_valid |-> (outst != 8'd0));
  p_data_held_r4: assert property (@(posedge rclk) disable iff (rrst)
    !rd_valid |-> $stable(rd_data));
endmodule

// File: tb/sim_dcm_dual_clock_mem.sv
`timescale 1ns/1ps
module sim_dcm_dual_clock_mem;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int RATIO = 2;
  localparam int LAT   = 4 + (5 + RATIO - 1) / RATIO;
  localparam int WORDS = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, wrst = 1'b1, rrst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  always #1 wclk = ~wclk;  // faster write clock
  always #2 rclk = ~rclk;  // 250 MHz read clock

  dcm_dual_clock_mem #(.ADDR_W(AW), .DATA_W(DW), .CLK_RATIO(RATIO), .FIFO_AW(3)) u0 (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {int cyc; logic [DW-1:0] d;} exp_t;
  exp_t          expq[$];
  logic [DW-1:0] model [WORDS];
  int            rcnt = 0, compared = 0, mismatched = 0;
  logic          chk_en = 1'b0, done = 1'b0;
  string         cur_req = "R7";
  logic [DW-1:0] last_d = '0;

  always @(posedge rclk) rcnt++;

  // reference comparison every read cycle
  always @(negedge rclk) begin
    if (chk_en) begin
      logic          ev;
      logic [DW-1:0] ed;
      ev = (expq.size() > 0) && (expq[0].cyc == rcnt);
      ed = ev ? expq[0].d : last_d;
      compared++;
      if (rd_valid !== ev || rd_data !== ed) begin
        mismatched++;
        $display("FAIL %s cycle %0d: actual valid=%0b data=%h expected valid=%0b data=%h",
                 cur_req, rcnt, rd_valid, rd_data, ev, ed);
      end
      if (ev) expq.delete(0);
      last_d = ed;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return 32'h1357_9BDF ^ (a * 32'h0101_0101) ^ (salt * 32'h00F0_0F00);
  endfunction

  task automatic wr_word(input int a, input logic [DW-1:0] d, input logic en);
    @(negedge wclk);
    wr_en = en; wr_addr = a[AW-1:0]; wr_data = d;
    if (en) model[a] = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd_word(input int a);
    rd_en = 1'b1; rd_addr = a[AW-1:0];
    expq.push_back('{rcnt + 1 + LAT, model[a]});
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge rclk);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (6) @(negedge rclk);
    wrst = 1'b0; rrst = 1'b0;
    chk_en = 1'b1;
    cur_req = "R7";  // reset state observed on the first compared cycles
    idle(3);

    cur_req = "R1";
    for (int i = 0; i < WORDS; i++) wr_word(i, pat(i, 0), 1'b1);
    @(negedge rclk); idle(2);

    cur_req = "R2";  // single read, exact return cycle
    rd_word(3); idle(LAT + 4);
    rd_word(WORDS - 1); idle(LAT + 4);  // R1 highest address

    cur_req = "R3";  // consecutive requests, in-order pulses
    for (int i = 0; i < 16; i++) rd_word(i);
    idle(LAT + 4);

    cur_req = "R4";  // gapped pattern, data held between pulses
    for (int i = 0; i < 6; i++) begin rd_word(40 + i); idle(i % 3); end
    idle(LAT + 4);

    cur_req = "R5";  // address sweep with rd_en low
    for (int i = 0; i < 12; i++) begin rd_addr = i[AW-1:0]; @(negedge rclk); end
    idle(LAT + 2);

    cur_req = "R6";  // write strobe low must not change memory
    wr_word(5, 32'hDEAD_BEEF, 1'b0);
    @(negedge rclk);
    rd_word(5); idle(LAT + 3);

    cur_req = "R9";  // second write to one address wins
    wr_word(7, pat(7, 1), 1'b1);
    wr_word(7, pat(7, 2), 1'b1);
    @(negedge rclk);
    rd_word(7); idle(LAT + 3);

    cur_req = "R8";  // long burst, queues must not overflow or starve
    for (int i = 0; i < 48; i++) rd_word((i * 5) % WORDS);
    idle(LAT + 6);

    cur_req = "R1";  // writes while reads are in flight to other words
    for (int i = 0; i < 4; i++) begin
      rd_word(i);
      wr_word(32 + i, pat(32 + i, 3), 1'b1);
      @(negedge rclk);
    end
    idle(LAT + 3);
    for (int i = 0; i < 4; i++) rd_word(32 + i);
    idle(LAT + 6);

    compared++;
    if (expq.size() != 0) begin
      mismatched++;
      $display("FAIL R3 leftover requests: actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule